// File: doc/BRIEF.md
# Load/Store Byte Lane Steering Unit

This block sits between a processor core and a data memory that is one 32-bit word wide. For a store it takes the access size, the low address bits and the register value. It returns the write word with the value copied into every lane that could be written, plus a per-byte write-enable mask that picks the lanes the memory actually updates. For a load it takes the word read from memory, the access size, the low address bits and a signed/unsigned select. It returns a full-width register value: the addressed byte or halfword, sign-extended or zero-extended, or the whole word.

Memory lane i always holds the byte at address offset i. The `BIG_ENDIAN` parameter chooses how bytes within a halfword or word map to significance. In little-endian order the byte at the lowest address is the least significant. In big-endian order it is the most significant, so word and halfword data are byte-reversed on the way in and on the way out. An access whose size requires alignment, and whose address does not meet it, is flagged and writes nothing. Both paths register their outputs, which gives one cycle of latency.

Top module: `lsl_lane_unit`

## Requirements
- R1: A synchronous active-high reset clears every output to zero. This includes wr_stb, wr_be, wr_data, st_err, ld_done, ld_result and ld_err.
- R2: Outputs appear one clock after the request. wr_stb follows st_valid and ld_done follows ld_valid by one cycle. A cycle without a store gives wr_be = 0 and wr_data = 0. A cycle without a load gives ld_result = 0.
- R3: The size code is 2'b00 for byte, 2'b01 for halfword and 2'b10 for word; 2'b11 is illegal. A word needs offset 0, and a halfword needs offset bit 0 = 0. A violation, or the illegal code, sets the error output and forces the results to zero: wr_be = 0 and wr_data = 0 for a store, ld_result = 0 for a load.
- R4: A byte store copies st_data[7:0] into all four lanes and sets only wr_be bit [offset].
- R5: A halfword store sets wr_be to 4'b0011 at offset 0 and to 4'b1100 at offset 2. The halfword is copied into both lane pairs. In little-endian mode an even lane takes st_data[7:0] and an odd lane takes st_data[15:8]; big-endian mode swaps these.
- R6: A word store sets wr_be = 4'b1111. wr_data equals st_data in little-endian mode and st_data byte-reversed in big-endian mode.
- R7: A byte load returns lane [offset] (mem_rdata[8*offset+7:8*offset]) in either endian mode. It is sign-extended when ld_unsigned = 0 and zero-extended when ld_unsigned = 1.
- R8: A halfword load at even offset o returns {lane o+1, lane o} in little-endian mode and {lane o, lane o+1} in big-endian mode. The result is extended as in R7.
- R9: A word load returns mem_rdata unchanged in little-endian mode and byte-reversed in big-endian mode. ld_unsigned has no effect on it.
- R10: After a word store of 0x12345678 at offset 0, a byte load at offset 0 of the stored word returns 0x12 in big-endian mode and 0x78 in little-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request this cycle |
| st_size | input | 2 | Store size code |
| st_addr_lo | input | 2 | Store address offset within the word |
| st_data | input | 32 | Register value to store |
| ld_valid | input | 1 | Load request this cycle |
| ld_size | input | 2 | Load size code |
| ld_addr_lo | input | 2 | Load address offset within the word |
| ld_unsigned | input | 1 | 1 selects zero-extension, 0 selects sign-extension |
| mem_rdata | input | 32 | Word read from data memory |
| wr_stb | output | 1 | Registered store strobe |
| wr_be | output | 4 | Per-lane write enables |
| wr_data | output | 32 | Lane-steered write word |
| st_err | output | 1 | Store was misaligned or had an illegal size |
| ld_done | output | 1 | Registered load strobe |
| ld_result | output | 32 | Extended load value |
| ld_err | output | 1 | Load was misaligned or had an illegal size |

## Verification
The hardest case to reach from the ports is the round trip across both byte orders. A value stored in one mode must read back with the correct significance, and that needs the write word to be fed back as the memory word one cycle later. The bench instantiates a little-endian and a big-endian copy side by side. It captures each copy's write word and returns it as that copy's own mem_rdata for the next load. Both alignment violations and the illegal size code are applied to both paths. Sign bits are set in the memory pattern, so that zero-extension and sign-extension give visibly different results.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsl_align_chk.sv
module lsl_align_chk #(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input  logic [1:0]       size,
  input  logic [OFS_W-1:0] ofs,
  output logic             ok
);
  import lsl_pkg::*;

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: ok = 1'b1;
      SZ_HALF: ok = ~ofs[0];
      SZ_WORD: ok = (ofs == '0);
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsl_store_path.sv
module lsl_store_path #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int NLANE = DATA_W / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input  logic [1:0]        size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              ok,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] wdata,
  output logic [NLANE-1:0]  be
);
  import lsl_pkg::*;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    // source byte of the halfword and of the word for this lane
    localparam int HSEL = BIG_ENDIAN ? (1 - (i % 2)) : (i % 2);
    localparam int WSEL = BIG_ENDIAN ? (NLANE - 1 - i) : i;
    localparam logic [OFS_W-1:0] IDX = OFS_W'(i);
    logic [7:0] lane_b;
    logic       lane_en;

    always_comb begin
      lane_b  = '0;
      lane_en = 1'b0;
      if (ok) begin
        case (acc_size_e'(size))
          SZ_BYTE: begin
            lane_b  = data[7:0];
            lane_en = (ofs == IDX);
          end
          SZ_HALF: begin
            lane_b  = data[8*HSEL +: 8];
            lane_en = (ofs[OFS_W-1:1] == IDX[OFS_W-1:1]);
          end
          SZ_WORD: begin
            lane_b  = data[8*WSEL +: 8];
            lane_en = 1'b1;
          end
          default: begin
            lane_b  = '0;
            lane_en = 1'b0;
          end
        endcase
      end
    end

    assign wdata[8*i +: 8] = lane_b;
    assign be[i]           = lane_en;
  end
endmodule

// File: rtl/lsl_load_path.sv
module lsl_load_path #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int NLANE = DATA_W / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input  logic [1:0]        size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              uns,
  input  logic              ok,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  import lsl_pkg::*;

  logic [7:0]        lane [NLANE];
  logic [DATA_W-1:0] word_v;
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;
  logic [OFS_W-1:0]  lo_ofs;
  logic [OFS_W-1:0]  hi_ofs;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign lane[i] = rdata[8*i +: 8];
    if (BIG_ENDIAN) begin : g_big
      assign word_v[8*i +: 8] = rdata[8*(NLANE-1-i) +: 8];
    end else begin : g_little
      assign word_v[8*i +: 8] = rdata[8*i +: 8];
    end
  end

  always_comb begin
    lo_ofs = {ofs[OFS_W-1:1], 1'b0};
    hi_ofs = {ofs[OFS_W-1:1], 1'b1};
    sel_b  = lane[ofs];
    sel_h  = BIG_ENDIAN ? {lane[lo_ofs], lane[hi_ofs]}
                        : {lane[hi_ofs], lane[lo_ofs]};
    result = '0;
    if (ok) begin
      case (acc_size_e'(size))
        SZ_BYTE: result = {{(DATA_W-8){sel_b[7] & ~uns}}, sel_b};
        SZ_HALF: result = {{(DATA_W-16){sel_h[15] & ~uns}}, sel_h};
        SZ_WORD: result = word_v;
        default: result = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsl_lane_unit.sv
module lsl_lane_unit #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int NLANE = DATA_W / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [1:0]        st_size,
  input  logic [OFS_W-1:0]  st_addr_lo,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  input  logic [1:0]        ld_size,
  input  logic [OFS_W-1:0]  ld_addr_lo,
  input  logic              ld_unsigned,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_stb,
  output logic [NLANE-1:0]  wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              st_err,
  output logic              ld_done,
  output logic [DATA_W-1:0] ld_result,
  output logic              ld_err
);
  logic              st_ok;
  logic              ld_ok;
  logic [DATA_W-1:0] st_wd;
  logic [NLANE-1:0]  st_be;
  logic [DATA_W-1:0] ld_val;

  lsl_align_chk #(.DATA_W(DATA_W)) u_st_align (
    .size(st_size), .ofs(st_addr_lo), .ok(st_ok)
  );

  lsl_align_chk #(.DATA_W(DATA_W)) u_ld_align (
    .size(ld_size), .ofs(ld_addr_lo), .ok(ld_ok)
  );

  lsl_store_path #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_store (
    .size(st_size), .ofs(st_addr_lo), .ok(st_ok), .data(st_data),
    .wdata(st_wd), .be(st_be)
  );

  lsl_load_path #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_load (
    .size(ld_size), .ofs(ld_addr_lo), .uns(ld_unsigned), .ok(ld_ok),
    .rdata(mem_rdata), .result(ld_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb    <= 1'b0;
      wr_be     <= '0;
      wr_data   <= '0;
      st_err    <= 1'b0;
      ld_done   <= 1'b0;
      ld_result <= '0;
      ld_err    <= 1'b0;
    end else begin
      wr_stb    <= st_valid;
      wr_be     <= st_valid ? st_be : '0;
      wr_data   <= st_valid ? st_wd : '0;
      st_err    <= st_valid & ~st_ok;
      ld_done   <= ld_valid;
      ld_result <= ld_valid ? ld_val : '0;
      ld_err    <= ld_valid & ~ld_ok;
    end
  end
endmodule

// File: rtl/lsl_lane_unit_chk.sv
module lsl_lane_unit_chk #(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic [1:0]        st_size,
  input logic [OFS_W-1:0]  st_addr_lo,
  input logic              ld_valid,
  input logic [1:0]        ld_size,
  input logic              ld_unsigned,
  input logic              wr_stb,
  input logic [NLANE-1:0]  wr_be,
  input logic [DATA_W-1:0] wr_data,
  input logic              st_err,
  input logic              ld_done,
  input logic [DATA_W-1:0] ld_result,
  input logic              ld_err
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!wr_stb && wr_be == '0 && !ld_done && ld_result == '0 && !st_err && !ld_err));

  // R2
  store_latency_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> wr_stb);

  // R2
  store_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !st_valid |=> (!wr_stb && wr_be == '0 && wr_data == '0));

  // R2
  load_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_done);

  // R3
  st_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    st_err |-> (wr_be == '0 && wr_data == '0));

  // R3
  ld_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ld_err |-> (ld_result == '0));

  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr_be) == 0 || $countones(wr_be) == 1 ||
     $countones(wr_be) == 2 || $countones(wr_be) == NLANE));

  // R6
  word_be_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_size == 2'b10 && st_addr_lo == '0) |=> (wr_be == '1));

  // R7
  ubyte_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_size == 2'b00 && ld_unsigned) |=> (ld_result[DATA_W-1:8] == '0));

  // R7
  sbyte_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_size == 2'b00 && !ld_unsigned) |=>
      (ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}}));
endmodule

bind lsl_lane_unit lsl_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_size(st_size),
  .st_addr_lo(st_addr_lo), .ld_valid(ld_valid), .ld_size(ld_size),
  .ld_unsigned(ld_unsigned), .wr_stb(wr_stb), .wr_be(wr_be),
  .wr_data(wr_data), .st_err(st_err), .ld_done(ld_done),
  .ld_result(ld_result), .ld_err(ld_err)
);

// File: tb/tb_lsl_lane_unit.sv
`timescale 1ns/1ps
module tb_lsl_lane_unit;
  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic [1:0]  ofs;
    logic        uns;
    logic [31:0] din;
    logic [31:0] exp_le;
    logic [31:0] exp_be;
    logic [3:0]  be;
    logic        err;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // stores, data A1B2C3D4
    '{1'b1, 2'b00, 2'd0, 1'b0, 32'hA1B2C3D4, 32'hD4D4D4D4, 32'hD4D4D4D4, 4'b0001, 1'b0},
    '{1'b1, 2'b00, 2'd3, 1'b0, 32'hA1B2C3D4, 32'hD4D4D4D4, 32'hD4D4D4D4, 4'b1000, 1'b0},
    '{1'b1, 2'b01, 2'd0, 1'b0, 32'hA1B2C3D4, 32'hC3D4C3D4, 32'hD4C3D4C3, 4'b0011, 1'b0},
    '{1'b1, 2'b01, 2'd2, 1'b0, 32'hA1B2C3D4, 32'hC3D4C3D4, 32'hD4C3D4C3, 4'b1100, 1'b0},
    '{1'b1, 2'b10, 2'd0, 1'b0, 32'hA1B2C3D4, 32'hA1B2C3D4, 32'hD4C3B2A1, 4'b1111, 1'b0},
    '{1'b1, 2'b10, 2'd0, 1'b0, 32'h12345678, 32'h12345678, 32'h78563412, 4'b1111, 1'b0},
    '{1'b1, 2'b01, 2'd1, 1'b0, 32'hA1B2C3D4, 32'h0,        32'h0,        4'b0000, 1'b1},
    '{1'b1, 2'b10, 2'd2, 1'b0, 32'hA1B2C3D4, 32'h0,        32'h0,        4'b0000, 1'b1},
    '{1'b1, 2'b11, 2'd0, 1'b0, 32'hA1B2C3D4, 32'h0,        32'h0,        4'b0000, 1'b1},
    // loads, memory word 80F17F02 (lane0=02 lane1=7F lane2=F1 lane3=80)
    '{1'b0, 2'b00, 2'd0, 1'b0, 32'h80F17F02, 32'h00000002, 32'h00000002, 4'b0000, 1'b0},
    '{1'b0, 2'b00, 2'd2, 1'b0, 32'h80F17F02, 32'hFFFFFFF1, 32'hFFFFFFF1, 4'b0000, 1'b0},
    '{1'b0, 2'b00, 2'd2, 1'b1, 32'h80F17F02, 32'h000000F1, 32'h000000F1, 4'b0000, 1'b0},
    '{1'b0, 2'b00, 2'd3, 1'b0, 32'h80F17F02, 32'hFFFFFF80, 32'hFFFFFF80, 4'b0000, 1'b0},
    '{1'b0, 2'b00, 2'd1, 1'b1, 32'h80F17F02, 32'h0000007F, 32'h0000007F, 4'b0000, 1'b0},
    '{1'b0, 2'b01, 2'd0, 1'b0, 32'h80F17F02, 32'h00007F02, 32'h0000027F, 4'b0000, 1'b0},
    '{1'b0, 2'b01, 2'd2, 1'b0, 32'h80F17F02, 32'hFFFF80F1, 32'hFFFFF180, 4'b0000, 1'b0},
    '{1'b0, 2'b01, 2'd2, 1'b1, 32'h80F17F02, 32'h000080F1, 32'h0000F180, 4'b0000, 1'b0},
    '{1'b0, 2'b10, 2'd0, 1'b0, 32'h80F17F02, 32'h80F17F02, 32'h027FF180, 4'b0000, 1'b0},
    '{1'b0, 2'b10, 2'd0, 1'b1, 32'h80F17F02, 32'h80F17F02, 32'h027FF180, 4'b0000, 1'b0},
    '{1'b0, 2'b01, 2'd3, 1'b0, 32'h80F17F02, 32'h0,        32'h0,        4'b0000, 1'b1},
    '{1'b0, 2'b10, 2'd1, 1'b0, 32'h80F17F02, 32'h0,        32'h0,        4'b0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0, ld_valid = 1'b0, ld_unsigned = 1'b0;
  logic [1:0]  st_size = '0, ld_size = '0, st_addr_lo = '0, ld_addr_lo = '0;
  logic [31:0] st_data = '0, mem_le = '0, mem_be = '0;

  logic        wr_stb_l, st_err_l, ld_done_l, ld_err_l;
  logic        wr_stb_b, st_err_b, ld_done_b, ld_err_b;
  logic [3:0]  wr_be_l, wr_be_b;
  logic [31:0] wr_data_l, wr_data_b, ld_result_l, ld_result_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsl_lane_unit #(.DATA_W(32), .BIG_ENDIAN(1'b0)) dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_size(st_size),
    .st_addr_lo(st_addr_lo), .st_data(st_data), .ld_valid(ld_valid),
    .ld_size(ld_size), .ld_addr_lo(ld_addr_lo), .ld_unsigned(ld_unsigned),
    .mem_rdata(mem_le), .wr_stb(wr_stb_l), .wr_be(wr_be_l), .wr_data(wr_data_l),
    .st_err(st_err_l), .ld_done(ld_done_l), .ld_result(ld_result_l), .ld_err(ld_err_l)
  );

  lsl_lane_unit #(.DATA_W(32), .BIG_ENDIAN(1'b1)) dut_be (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_size(st_size),
    .st_addr_lo(st_addr_lo), .st_data(st_data), .ld_valid(ld_valid),
    .ld_size(ld_size), .ld_addr_lo(ld_addr_lo), .ld_unsigned(ld_unsigned),
    .mem_rdata(mem_be), .wr_stb(wr_stb_b), .wr_be(wr_be_b), .wr_data(wr_data_b),
    .st_err(st_err_b), .ld_done(ld_done_b), .ld_result(ld_result_b), .ld_err(ld_err_b)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err) return "R3";
    if (v.st) begin
      case (v.sz)
        2'b00:   return "R4";
        2'b01:   return "R5";
        default: return "R6";
      endcase
    end
    case (v.sz)
      2'b00:   return "R7";
      2'b01:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_all_zero(input string tag);
    chk(tag, "le wr_stb", {31'b0, wr_stb_l}, 32'h0);
    chk(tag, "le wr_be", {28'b0, wr_be_l}, 32'h0);
    chk(tag, "le wr_data", wr_data_l, 32'h0);
    chk(tag, "le ld_done/errs", {29'b0, ld_done_l, st_err_l, ld_err_l}, 32'h0);
    chk(tag, "le ld_result", ld_result_l, 32'h0);
    chk(tag, "be outputs", {25'b0, wr_stb_b, wr_be_b, ld_done_b, st_err_b, ld_err_b}, 32'h0);
    chk(tag, "be data", wr_data_b | ld_result_b, 32'h0);
  endtask

  initial begin
    logic [31:0] cap_l, cap_b;
    repeat (3) @(negedge clk);
    check_all_zero("R1");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = tag_of(v);
      @(negedge clk);
      st_valid = v.st;  ld_valid = ~v.st;
      st_size = v.sz;   ld_size = v.sz;
      st_addr_lo = v.ofs; ld_addr_lo = v.ofs;
      ld_unsigned = v.uns;
      st_data = v.din;  mem_le = v.din;  mem_be = v.din;
      @(negedge clk);
      st_valid = 1'b0;  ld_valid = 1'b0;
      if (v.st) begin
        chk(tg, "le wr_data", wr_data_l, v.exp_le);
        chk(tg, "be wr_data", wr_data_b, v.exp_be);
        chk(tg, "le wr_be", {28'b0, wr_be_l}, {28'b0, v.be});
        chk(tg, "be wr_be", {28'b0, wr_be_b}, {28'b0, v.be});
        chk("R3", "st_err le/be", {30'b0, st_err_l, st_err_b}, {30'b0, v.err, v.err});
        chk("R2", "strobes after store", {30'b0, wr_stb_l, ld_done_l}, 32'h2);
      end else begin
        chk(tg, "le ld_result", ld_result_l, v.exp_le);
        chk(tg, "be ld_result", ld_result_b, v.exp_be);
        chk("R3", "ld_err le/be", {30'b0, ld_err_l, ld_err_b}, {30'b0, v.err, v.err});
        chk("R2", "idle store lanes on load", {28'b0, wr_be_l}, 32'h0);
        chk("R2", "strobes after load", {30'b0, wr_stb_l, ld_done_l}, 32'h1);
      end
    end

    // R2: registered latency - output still idle before the capturing edge
    @(negedge clk);
    st_valid = 1'b1; st_size = 2'b00; st_addr_lo = 2'd1; st_data = 32'h0000005A;
    #1;
    chk("R2", "wr_stb before edge", {31'b0, wr_stb_l}, 32'h0);
    @(negedge clk);
    st_valid = 1'b0;
    chk("R2", "wr_stb after edge", {31'b0, wr_stb_l}, 32'h1);
    chk("R4", "byte store offset 1 be", {28'b0, wr_be_l}, 32'h2);
    @(negedge clk);
    chk("R2", "idle store data", wr_data_l | {28'b0, wr_be_l}, 32'h0);

    // R10: store word, feed each copy's write word back and read byte 0
    st_valid = 1'b1; st_size = 2'b10; st_addr_lo = 2'd0; st_data = 32'h12345678;
    @(negedge clk);
    cap_l = wr_data_l; cap_b = wr_data_b;
    st_valid = 1'b0;
    ld_valid = 1'b1; ld_size = 2'b00; ld_addr_lo = 2'd0; ld_unsigned = 1'b1;
    mem_le = cap_l; mem_be = cap_b;
    @(negedge clk);
    chk("R10", "little-endian byte 0", ld_result_l, 32'h00000078);
    chk("R10", "big-endian byte 0", ld_result_b, 32'h00000012);
    ld_size = 2'b10; ld_unsigned = 1'b0;
    @(negedge clk);
    chk("R10", "little-endian word round trip", ld_result_l, 32'h12345678);
    chk("R10", "big-endian word round trip", ld_result_b, 32'h12345678);

    // R1: reset in the middle of traffic clears outputs
    ld_size = 2'b01; ld_addr_lo = 2'd2; mem_le = 32'hFFFF0000; mem_be = 32'hFFFF0000;
    @(negedge clk);
    chk("R8", "halfword before reset", ld_result_l, 32'hFFFFFFFF);
    rst = 1'b1;
    st_valid = 1'b1; st_size = 2'b10;
    @(negedge clk);
    check_all_zero("R1");
    rst = 1'b0; st_valid = 1'b0; ld_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule